// File: doc/BRIEF.md
# Caption Decoder Control Front End

This block sits at the control edge of a line-21 caption decoder. Three shared control pins carry either static settings or a serial command stream, and a mode pin decides which. When the mode pin is high, the pins are read as levels: one turns the decoder on, one picks the language, and one picks captions or text. The language and captions/text pins together name one of four data channels. When the mode pin is low, the same pins act as a serial enable, a serial clock and a serial data line. Eight-bit commands arriving on them load a configuration register, or request one of two reset levels.

The block produces the decoder-enable and channel-select levels, and two single-cycle pulses. The full-reset pulse restarts the whole decoder. The command-processor reset pulse tells downstream logic to clear the caption display and wait for fresh line-21 data, while video timing keeps running. The active-low reset pin also performs a full reset. In serial mode it may be tied high, and the serial stream then provides the full reset.

All pin inputs pass through two-flop synchronizers into the system clock domain. Edges of the serial clock and the serial enable are detected there.

Top module: `cc_ctl_frontend`

## Requirements
- R1: While the mode pin is high, the three outputs follow the three control pins, after synchronization, within four clock cycles of a pin change.
- R2: In parallel mode, a high on `ctl_en_i` means decoder on. A high on `ctl_lng_i` means language I (low means language II). A high on `ctl_ct_i` means captions (low means text). All four language/type combinations reach the outputs unchanged.
- R3: In serial mode, `ctl_lng_i` is the serial clock, `ctl_ct_i` is serial data and `ctl_en_i` is the serial enable. A data bit is taken on each rising serial-clock edge while the enable is high, most significant bit first.
- R4: A command takes effect only when the enable falls after exactly eight bits. A word of seven or nine bits leaves the outputs and the pulses unchanged.
- R5: A command whose upper nibble is 0x1 loads the configuration: bit 0 is decoder on, bit 1 is language I and bit 2 is captions. In serial mode the outputs show this configuration.
- R6: Command 0x01 gives a one-cycle `full_rst_o` pulse and restores the default configuration: decoder off, language I, captions.
- R7: Command 0x02 gives a one-cycle `cp_rst_o` pulse and leaves the configuration unchanged. `full_rst_o` and `cp_rst_o` are never high in the same cycle.
- R8: While `rst_n` is low, all state takes its reset values and the configuration is the default. In the first cycle after `rst_n` rises, `full_rst_o` pulses once.
- R9: Command codes other than 0x01, 0x02 and 0x1X, such as 0x00 and 0x25, change nothing.
- R10: If `rst_n` goes low while a serial command is completing, that command is dropped. Only the full-reset pulse that follows the pin's release appears.
- R11: In parallel mode, serial-looking activity on the pins produces no pulse and leaves the serial configuration unchanged. The unchanged configuration is seen on the outputs after returning to serial mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset pin, sampled synchronously |
| mode_par_i | input | 1 | High: parallel pin levels; low: serial command stream |
| ctl_en_i | input | 1 | Decoder on/off level, or serial enable |
| ctl_lng_i | input | 1 | Language select level, or serial clock |
| ctl_ct_i | input | 1 | Captions/text select level, or serial data |
| dec_on_o | output | 1 | Decoder enable |
| lang1_o | output | 1 | High: language I; low: language II |
| capt_o | output | 1 | High: captions; low: text |
| full_rst_o | output | 1 | One-cycle full-reset pulse |
| cp_rst_o | output | 1 | One-cycle command-processor reset pulse |

## Verification
A serial command can complete in the same cycle that the reset pin is pulled low. The bench provokes this by dropping the serial enable and `rst_n` at the same instant after a full 0x02 word. The scoreboard then expects exactly one full-reset pulse after release, with no command-processor pulse and with the default configuration on the outputs. A second collision happens when the mode pin switches while serial-looking traffic is on the pins. The bench judges it by the absence of any pulse and by the configuration that is read back after returning to serial mode.

// File: rtl/cc_ctl_pkg.sv
package cc_ctl_pkg;
    localparam int WORD_W = 8;

    typedef struct packed {
        logic dec_on;
        logic lang1;
        logic capt;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{dec_on: 1'b0, lang1: 1'b1, capt: 1'b1};

    localparam logic [7:0] OP_FULL   = 8'h01;
    localparam logic [7:0] OP_CPR    = 8'h02;
    localparam logic [3:0] OP_CFG_HI = 4'h1;
endpackage

// File: rtl/cc_ctl_sync.sv
module cc_ctl_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [W-1:0] st_d, st_q;
        if (s == 0) begin : g_first
            assign st_d = d_i;
        end else begin : g_next
            assign st_d = g_stage[s-1].st_q;
        end
        always_ff @(posedge clk) begin
            st_q <= rst_n ? st_d : '0;
        end
    end

    assign q_o = g_stage[STAGES-1].st_q;
endmodule

// File: rtl/cc_ctl_serrx.sv
module cc_ctl_serrx #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              sclk_i,
    input  logic              sdat_i,
    input  logic              sen_i,
    output logic              cmd_valid_o,
    output logic [WORD_W-1:0] cmd_o
);
    localparam int CNT_MAX = WORD_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic              sclk_prev;
        logic              sen_prev;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shreg;
        logic              valid;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d           = rx_q;
        rx_d.valid     = 1'b0;
        rx_d.sclk_prev = sclk_i;
        rx_d.sen_prev  = sen_i;
        if (!active_i) begin
            rx_d.cnt = '0;
        end else if (sen_i && !rx_q.sen_prev) begin
            rx_d.cnt = '0;
        end else if (!sen_i && rx_q.sen_prev) begin
            rx_d.valid = (rx_q.cnt == CNT_W'(WORD_W));
            rx_d.cnt   = '0;
        end else if (sen_i && sclk_i && !rx_q.sclk_prev) begin
            rx_d.shreg = {rx_q.shreg[WORD_W-2:0], sdat_i};
            if (rx_q.cnt != CNT_W'(CNT_MAX)) begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        rx_q <= rst_n ? rx_d : '0;
    end

    assign cmd_valid_o = rx_q.valid;
    assign cmd_o       = rx_q.shreg;

    // R4
    word_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.valid |-> $past(rx_q.cnt) == CNT_W'(WORD_W));

    // R11
    par_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !rx_q.valid);
endmodule

// File: rtl/cc_ctl_cmd.sv
module cc_ctl_cmd
    import cc_ctl_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [WORD_W-1:0] cmd_i,
    output cfg_t              cfg_o,
    output logic              full_pulse_o,
    output logic              cp_pulse_o
);
    typedef struct packed {
        cfg_t cfg;
        logic armed;
        logic full;
        logic cp;
    } cmd_t;

    localparam cmd_t CMD_RST = '{cfg: CFG_DEFAULT, armed: 1'b0, full: 1'b0, cp: 1'b0};

    cmd_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.full = 1'b0;
        st_d.cp   = 1'b0;
        if (!st_q.armed) begin
            st_d.armed = 1'b1;
            st_d.full  = 1'b1;
            st_d.cfg   = CFG_DEFAULT;
        end else if (cmd_valid_i) begin
            if (cmd_i[7:0] == OP_FULL) begin
                st_d.full = 1'b1;
                st_d.cfg  = CFG_DEFAULT;
            end else if (cmd_i[7:0] == OP_CPR) begin
                st_d.cp = 1'b1;
            end else if (cmd_i[7:4] == OP_CFG_HI) begin
                st_d.cfg = '{dec_on: cmd_i[0], lang1: cmd_i[1], capt: cmd_i[2]};
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= rst_n ? st_d : CMD_RST;
    end

    assign cfg_o        = st_q.cfg;
    assign full_pulse_o = st_q.full;
    assign cp_pulse_o   = st_q.cp;

    // R6
    full_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full |=> !st_q.full);

    // R7
    cp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cp |=> !st_q.cp);

    // R7
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.full && st_q.cp));

    // R6
    full_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full |-> st_q.cfg == CFG_DEFAULT);

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && !cmd_valid_i) |=> $stable(st_q.cfg));
endmodule

// File: rtl/cc_ctl_frontend.sv
module cc_ctl_frontend
    import cc_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CMD_W       = WORD_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_par_i,
    input  logic ctl_en_i,
    input  logic ctl_lng_i,
    input  logic ctl_ct_i,
    output logic dec_on_o,
    output logic lang1_o,
    output logic capt_o,
    output logic full_rst_o,
    output logic cp_rst_o
);
    localparam int PIN_N = 4;

    logic [PIN_N-1:0] pins_s;
    logic             mode_s, en_s, lng_s, ct_s;
    logic             cmd_valid;
    logic [CMD_W-1:0] cmd;
    cfg_t             cfg_q;

    cc_ctl_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({mode_par_i, ctl_en_i, ctl_lng_i, ctl_ct_i}),
        .q_o   (pins_s)
    );

    assign {mode_s, en_s, lng_s, ct_s} = pins_s;

    cc_ctl_serrx #(.WORD_W(CMD_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (!mode_s),
        .sclk_i      (lng_s),
        .sdat_i      (ct_s),
        .sen_i       (en_s),
        .cmd_valid_o (cmd_valid),
        .cmd_o       (cmd)
    );

    cc_ctl_cmd #(.WORD_W(CMD_W)) u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid_i  (cmd_valid),
        .cmd_i        (cmd),
        .cfg_o        (cfg_q),
        .full_pulse_o (full_rst_o),
        .cp_pulse_o   (cp_rst_o)
    );

    always_comb begin
        if (mode_s) begin
            dec_on_o = en_s;
            lang1_o  = lng_s;
            capt_o   = ct_s;
        end else begin
            dec_on_o = cfg_q.dec_on;
            lang1_o  = cfg_q.lang1;
            capt_o   = cfg_q.capt;
        end
    end

    // R8
    boot_pulse_chk: assert property (@(posedge clk)
        $rose(rst_n) |=> full_rst_o);

    // R11
    par_no_cp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s && $past(mode_s) && $past(mode_s, 2)) |-> !cp_rst_o);
endmodule

// File: tb/tb_cc_ctl_frontend.sv
module tb_cc_ctl_frontend;
    logic clk = 1'b0;
    logic rst_n, mode_par_i, ctl_en_i, ctl_lng_i, ctl_ct_i;
    logic dec_on_o, lang1_o, capt_o, full_rst_o, cp_rst_o;

    int n_vec  = 0;
    int n_fail = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #10 clk = ~clk;

    cc_ctl_frontend dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_par_i (mode_par_i),
        .ctl_en_i   (ctl_en_i),
        .ctl_lng_i  (ctl_lng_i),
        .ctl_ct_i   (ctl_ct_i),
        .dec_on_o   (dec_on_o),
        .lang1_o    (lang1_o),
        .capt_o     (capt_o),
        .full_rst_o (full_rst_o),
        .cp_rst_o   (cp_rst_o)
    );

    // monitor: 1 = full reset pulse, 2 = command-processor pulse
    always @(negedge clk) begin
        if (rst_n === 1'b1 && (full_rst_o || cp_rst_o)) begin
            int got;
            got = full_rst_o ? 1 : 2;
            n_vec++;
            if (full_rst_o && cp_rst_o) begin
                n_fail++;
                $display("FAIL R7 both pulses high: got 11 expected one");
            end else if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R6/R7 unexpected pulse: got %0d expected none", got);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != got) begin
                    n_fail++;
                    $display("FAIL R6/R7 pulse kind: got %0d expected %0d", got, e);
                end
            end
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_out(logic e_on, logic e_lng, logic e_ct, string req);
        wait_clk(6);
        n_vec++;
        if ({dec_on_o, lang1_o, capt_o} !== {e_on, e_lng, e_ct}) begin
            n_fail++;
            $display("FAIL %s outputs: got %b%b%b expected %b%b%b", req,
                     dec_on_o, lang1_o, capt_o, e_on, e_lng, e_ct);
        end
    endtask

    task automatic send_word(logic [15:0] bits, int n, bit abort);
        ctl_en_i = 1'b1;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) begin
            ctl_ct_i = bits[i];
            wait_clk(4);
            ctl_lng_i = 1'b1;
            wait_clk(4);
            ctl_lng_i = 1'b0;
            wait_clk(4);
        end
        ctl_en_i = 1'b0;
        if (abort) begin
            rst_n = 1'b0;
            wait_clk(5);
            rst_n = 1'b1;
        end
        wait_clk(12);
    endtask

    task automatic set_pins(logic a, logic b, logic c);
        ctl_en_i  = a;
        ctl_lng_i = b;
        ctl_ct_i  = c;
    endtask

    initial begin
        rst_n = 1'b0; mode_par_i = 1'b0;
        set_pins(1'b0, 1'b0, 1'b0);
        wait_clk(5);
        // R8: reset state
        n_vec++;
        if ({dec_on_o, lang1_o, capt_o, full_rst_o, cp_rst_o} !== 5'b01100) begin
            n_fail++;
            $display("FAIL R8 reset state: got %b expected 01100",
                     {dec_on_o, lang1_o, capt_o, full_rst_o, cp_rst_o});
        end
        exp_q.push_back(1);
        rst_n = 1'b1;
        check_out(1'b0, 1'b1, 1'b1, "R8");

        // R5 / R3: configuration words, MSB first
        send_word(16'h15, 8, 1'b0); check_out(1'b1, 1'b0, 1'b1, "R5");
        send_word(16'h1E, 8, 1'b0); check_out(1'b0, 1'b1, 1'b1, "R5");
        send_word(16'h13, 8, 1'b0); check_out(1'b1, 1'b1, 1'b0, "R3");

        // R4: wrong bit counts discarded
        send_word(16'h15, 7, 1'b0);  check_out(1'b1, 1'b1, 1'b0, "R4");
        send_word(16'h015, 9, 1'b0); check_out(1'b1, 1'b1, 1'b0, "R4");

        // R7: command-processor reset keeps configuration
        exp_q.push_back(2);
        send_word(16'h02, 8, 1'b0); check_out(1'b1, 1'b1, 1'b0, "R7");

        // R9: unknown codes ignored
        send_word(16'h00, 8, 1'b0); check_out(1'b1, 1'b1, 1'b0, "R9");
        send_word(16'h25, 8, 1'b0); check_out(1'b1, 1'b1, 1'b0, "R9");

        // R6: serial full reset restores defaults
        exp_q.push_back(1);
        send_word(16'h01, 8, 1'b0); check_out(1'b0, 1'b1, 1'b1, "R6");

        // R10: reset pin collides with completing command
        send_word(16'h17, 8, 1'b0); check_out(1'b1, 1'b1, 1'b1, "R5");
        exp_q.push_back(1);
        send_word(16'h02, 8, 1'b1); check_out(1'b0, 1'b1, 1'b1, "R10");

        // R1 / R2: parallel levels, all four channels
        mode_par_i = 1'b1;
        set_pins(1'b1, 1'b1, 1'b1); check_out(1'b1, 1'b1, 1'b1, "R2");
        set_pins(1'b1, 1'b0, 1'b1); check_out(1'b1, 1'b0, 1'b1, "R2");
        set_pins(1'b0, 1'b1, 1'b0); check_out(1'b0, 1'b1, 1'b0, "R1");
        set_pins(1'b1, 1'b0, 1'b0); check_out(1'b1, 1'b0, 1'b0, "R1");
        set_pins(1'b0, 1'b0, 1'b0);

        // R11: serial-looking traffic in parallel mode
        mode_par_i = 1'b0;
        wait_clk(6);
        send_word(16'h17, 8, 1'b0); check_out(1'b1, 1'b1, 1'b1, "R11");
        mode_par_i = 1'b1;
        wait_clk(6);
        send_word(16'h01, 8, 1'b0);
        send_word(16'h02, 8, 1'b0);
        send_word(16'h10, 8, 1'b0);
        set_pins(1'b0, 1'b0, 1'b0);
        check_out(1'b0, 1'b0, 1'b0, "R11");
        mode_par_i = 1'b0;
        check_out(1'b1, 1'b1, 1'b1, "R11");

        wait_clk(20);
        n_vec++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R6/R7/R10 missing pulses: got %0d left expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule